// File: doc/BRIEF.md
# Windowed Trigger Watchdog with Hysteresis

This block watches a periodic trigger from a microcontroller and decides whether the controller is healthy. A free-running time-base clock measures the interval between successive rising edges of the trigger. When an edge arrives, the block grades the interval as good or bad. A bad interval is one that is too short or too long. The grade moves a score that saturates between 0 and 3. A set/reset verdict flag turns on when the score reaches 3 and turns off only when the score falls back to 0. A single stray pulse therefore never flips the verdict.

While the verdict is healthy, both edges of the acceptance window move one clock earlier. This gives the good/bad decision hysteresis. If no edge arrives for a fixed dropout time, the verdict drops at once. It also drops while an oscillator-error line is raised, so a stalled time base cannot hold a healthy verdict. The trigger and the error line are asynchronous and are synchronised into the time-base domain first. The verdict is meant to drive enable and reset logic elsewhere.

Top module: `trigwin_supervisor`

## Requirements
- R1: The score saturates. A good interval at score 3 leaves it at 3, and a bad interval at score 0 leaves it at 0.
- R2: The interval is the number of clock cycles between two successive rising edges of the trigger. With the flag clear, an interval from 80 to 170 inclusive is good and any other interval is bad. The score and flag outputs reflect an edge 3 clock cycles after the trigger rises: two synchroniser stages plus one state register.
- R3: A good interval raises the score by 1 and a bad interval lowers it by 1.
- R4: The flag becomes 1 when the score becomes 3 and becomes 0 when the score becomes 0. At scores 1 and 2 the flag keeps its previous value.
- R5: Suppose 250 clock cycles pass after the last edge with no new edge. On the 250th cycle the score becomes 0 and the flag becomes 0.
- R6: While the synchronised oscillator-error input is 1, the score is held at 0 and the flag at 0, and trigger edges have no effect. The forcing takes effect 3 clock cycles after the input rises.
- R7: A synchronous active-high reset sets the score to 0 and the flag to 0 on the next clock edge.
- R8: With the flag set, the good window is 79 to 169 inclusive. An interval of 79 is good and an interval of 170 is bad. The dropout limit of 250 does not change.
- R9: After a dropout the interval counter stays at its limit rather than wrapping. An edge that follows any longer gap, for example 356 cycles, is graded bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Time-base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger from the supervised controller |
| osc_err_i | input | 1 | Asynchronous time-base failure indication, active high |
| score_o | output | 2 | Current score, 0 to 3 |
| wd_ok_o | output | 1 | Verdict flag, 1 means healthy |

## Verification
The bench builds the block with its default limits of 80, 170 and 250 clocks and a two-stage synchroniser. This keeps every window edge on both sides of the hysteresis (79, 80, 169, 170, 171) within a few hundred cycles per trigger. The 8-bit counter that these limits imply makes a 356-cycle gap a real test of wrap-around, because a wrapped counter would read 100 and grade the edge good. The 250-cycle dropout can be probed on the exact cycle it lands.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef logic [1:0] score_t;

    localparam score_t SCORE_TOP = 2'd3;
    localparam score_t SCORE_BOT = 2'd0;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN,
        STEP_CLEAR
    } step_e;

    typedef struct packed {
        score_t score;
        logic   ok;
    } verdict_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_interval.sv
module tw_interval #(
    parameter int LO_LIM   = 80,
    parameter int HI_LIM   = 170,
    parameter int DROP_LIM = 250
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_s_i,
    input  logic ok_i,
    output logic edge_o,
    output logic good_o,
    output logic timeout_o
);

    localparam int CW = $clog2(DROP_LIM + 1);
    localparam logic [CW-1:0] LO_W   = CW'(LO_LIM);
    localparam logic [CW-1:0] HI_W   = CW'(HI_LIM);
    localparam logic [CW-1:0] DROP_W = CW'(DROP_LIM);
    localparam logic [CW-1:0] ONE_W  = CW'(1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } ivl_t;

    ivl_t          st_d, st_q;
    logic          rise;
    logic [CW-1:0] lo_b, hi_b;

    always_comb begin
        st_d      = st_q;
        st_d.prev = trig_s_i;
        rise      = trig_s_i & ~st_q.prev;

        if (rise)                   st_d.cnt = ONE_W;
        else if (st_q.cnt != DROP_W) st_d.cnt = st_q.cnt + ONE_W;

        lo_b = ok_i ? (LO_W - ONE_W) : LO_W;
        hi_b = ok_i ? (HI_W - ONE_W) : HI_W;

        edge_o    = rise;
        good_o    = rise && (st_q.cnt >= lo_b) && (st_q.cnt <= hi_b);
        timeout_o = !rise && (st_q.cnt == DROP_W);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/tw_verdict.sv
module tw_verdict
    import tw_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   edge_i,
    input  logic   good_i,
    input  logic   timeout_i,
    input  logic   fault_i,
    output score_t score_o,
    output logic   ok_o
);

    verdict_t v_d, v_q;
    step_e    step;

    always_comb begin
        if (fault_i || timeout_i)                    step = STEP_CLEAR;
        else if (edge_i && good_i && v_q.score != SCORE_TOP)  step = STEP_UP;
        else if (edge_i && !good_i && v_q.score != SCORE_BOT) step = STEP_DOWN;
        else                                         step = STEP_HOLD;

        v_d = v_q;
        unique case (step)
            STEP_CLEAR: v_d.score = SCORE_BOT;
            STEP_UP:    v_d.score = v_q.score + 2'd1;
            STEP_DOWN:  v_d.score = v_q.score - 2'd1;
            default:    v_d.score = v_q.score;
        endcase

        if (v_d.score == SCORE_TOP)      v_d.ok = 1'b1;
        else if (v_d.score == SCORE_BOT) v_d.ok = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) v_q <= '0;
        else       v_q <= v_d;
    end

    assign score_o = v_q.score;
    assign ok_o    = v_q.ok;

endmodule

// File: rtl/trigwin_supervisor.sv
module trigwin_supervisor #(
    parameter int LO_LIM      = 80,
    parameter int HI_LIM      = 170,
    parameter int DROP_LIM    = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       trig_i,
    input  logic       osc_err_i,
    output logic [1:0] score_o,
    output logic       wd_ok_o
);

    logic trig_s_w, osc_s_w;
    logic edge_w, good_w, timeout_w;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync_trig (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (trig_i),
        .q_o   (trig_s_w)
    );

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (osc_err_i),
        .q_o   (osc_s_w)
    );

    tw_interval #(
        .LO_LIM   (LO_LIM),
        .HI_LIM   (HI_LIM),
        .DROP_LIM (DROP_LIM)
    ) u_interval (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .trig_s_i  (trig_s_w),
        .ok_i      (wd_ok_o),
        .edge_o    (edge_w),
        .good_o    (good_w),
        .timeout_o (timeout_w)
    );

    tw_verdict u_verdict (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .edge_i    (edge_w),
        .good_i    (good_w),
        .timeout_i (timeout_w),
        .fault_i   (osc_s_w),
        .score_o   (score_o),
        .ok_o      (wd_ok_o)
    );

endmodule

// File: rtl/trigwin_checker.sv
module trigwin_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       edge_i,
    input logic       good_i,
    input logic       timeout_i,
    input logic       fault_i,
    input logic [1:0] score_i,
    input logic       ok_i
);

    // R1: a good interval at the top score keeps the top score
    assert_top_saturates_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (score_i == 2'd3 && edge_i && good_i && !fault_i) |=> (score_i == 2'd3));

    // R3: a bad interval above the floor lowers the score by exactly one
    assert_bad_decrements_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (score_i != 2'd0 && edge_i && !good_i && !fault_i) |=> (score_i == $past(score_i) - 2'd1));

    // R4: the flag agrees with the score at both ends
    assert_flag_at_top_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (score_i == 2'd3) |-> ok_i);

    assert_flag_at_floor_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (score_i == 2'd0) |-> !ok_i);

    // R5: a dropout clears score and flag
    assert_dropout_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_i |=> (score_i == 2'd0 && !ok_i));

    // R6: a time-base fault clears score and flag
    assert_fault_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_i |=> (score_i == 2'd0 && !ok_i));

    // R7: reset leads to the initial state
    assert_reset_state_R7: assert property (@(posedge clk_i)
        rst_i |=> (score_i == 2'd0 && !ok_i));

    // R9: the dropout persists until an edge arrives
    assert_dropout_sticks_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_i |=> (timeout_i || edge_i));

endmodule

bind trigwin_supervisor trigwin_checker u_checker (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .edge_i    (edge_w),
    .good_i    (good_w),
    .timeout_i (timeout_w),
    .fault_i   (osc_s_w),
    .score_i   (score_o),
    .ok_i      (wd_ok_o)
);

// File: tb/tb_trigwin_supervisor.sv
module tb_trigwin_supervisor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic       osc_err = 1'b0;
    logic [1:0] score;
    logic       ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    trigwin_supervisor dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .trig_i    (trig),
        .osc_err_i (osc_err),
        .score_o   (score),
        .wd_ok_o   (ok)
    );

    localparam int NV = 20;
    localparam int GAP   [NV] = '{100, 100, 100, 100, 40, 200, 79, 169, 60, 60,
                                  60, 60, 79, 80, 170, 171, 170, 80, 170, 169};
    localparam int EXP_S [NV] = '{1, 2, 3, 3, 2, 1, 2, 3, 2, 1,
                                  0, 0, 0, 1, 2, 1, 2, 3, 2, 3};
    localparam int EXP_OK[NV] = '{0, 0, 1, 1, 1, 1, 1, 1, 1, 1,
                                  0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

    task automatic check(input string tag, input int exp_s, input int exp_ok);
        n_checks++;
        if (int'(score) != exp_s || int'(ok) != exp_ok) begin
            n_fail++;
            $display("FAIL %s: score=%0d ok=%0d expected score=%0d ok=%0d",
                     tag, score, ok, exp_s, exp_ok);
        end
    endtask

    // one-cycle trigger pulse; returns at the negedge after the result lands
    task automatic trig_event();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // next trigger rises gap cycles after the previous rise
    task automatic send(input int gap);
        repeat (gap - 3) @(negedge clk);
        trig_event();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset state", 0, 0);
        rst = 1'b0;

        // first edge after reset: short interval, bad at the floor
        trig_event();
        check("R1/R3 first edge at floor", 0, 0);

        for (int i = 0; i < NV; i++) begin
            send(GAP[i]);
            check($sformatf("R2/R3/R4/R8 vector %0d gap %0d", i, GAP[i]),
                  EXP_S[i], EXP_OK[i]);
        end

        // dropout boundary (R5)
        repeat (249) @(negedge clk);
        check("R5 one cycle before dropout", 3, 1);
        @(negedge clk);
        check("R5 dropout on 250th cycle", 0, 0);
        repeat (50) @(negedge clk);
        check("R5 dropout repeats", 0, 0);

        // gap of 356 total: a wrapped counter would read 100
        repeat (53) @(negedge clk);
        trig_event();
        check("R9 long gap graded bad", 0, 0);

        send(100);
        send(100);
        send(100);
        check("R4 rebuilt to healthy", 3, 1);

        // oscillator error (R6)
        osc_err = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 before sync delay", 3, 1);
        @(negedge clk);
        check("R6 forced clear", 0, 0);
        repeat (94) @(negedge clk);
        trig_event();
        check("R6 good edge ignored under fault", 0, 0);
        osc_err = 1'b0;
        send(100);
        check("R6 recovery after fault", 1, 0);

        // synchronous reset mid-run (R7)
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset mid-run", 0, 0);
        rst = 1'b0;
        trig_event();
        send(100);
        check("R7 normal after reset", 1, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog expired: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule